// File: doc/BRIEF.md
# One-Wire ROM Search Accelerator

This block sits between a host-facing byte exchange port and a bit-slot engine that times individual one-wire slots. In its plain mode each accepted byte becomes eight slots, least significant bit first. Each slot drives one bit of the byte and the sampled bus level lands in the same bit position of the returned byte.

With search assist enabled, one byte exchange resolves four consecutive ROM positions of a device search. For every position the block runs three slots. The first two are read slots that sample the true bit and its complement. The third writes the chosen branch back to the bus. The returned byte carries the chosen bit and a conflict flag for each position. Sixteen such exchanges cover a full 64-bit identifier.

The host raises the enable only after it has issued the bus reset and the search command byte. It keeps its own record of which branch to prefer on the next pass, and it passes that preference in through the odd bits of the byte it sends.

Top module: `owsra_top`

## Requirements
- R1: After reset, tx_ready_o is 1, and rx_valid_o, slot_req_o, pass_done_o and exch_idx_o are all 0.
- R2: In plain mode an exchange runs exactly BYTE_W slots. Slot k drives tx bit k, starting with bit 0. The level sampled in slot k becomes rx bit k. rx_valid_o is high for one cycle, the cycle after the final slot_done_i.
- R3: In search mode an exchange runs 3·(BYTE_W/2) slots in groups of three. The first two slots of a group drive 1, so they act as read slots. The third drives the chosen direction.
- R4: When the true sample and the complement sample differ, the chosen bit equals the true sample and the conflict flag is 0.
- R5: When both samples are 0, the conflict flag is 1 and the chosen bit is the preference bit: tx bit 2p+1 for position p.
- R6: When both samples are 1 (nobody answered), the conflict flag is 1 and the chosen bit is 1.
- R7: For position p (p=0 first), rx bit 2p+1 holds the chosen bit and rx bit 2p holds the conflict flag. Over a pass, exchange i supplies ROM bits 4i to 4i+3.
- R8: exch_idx_o counts completed search-mode exchanges. Plain exchanges leave it unchanged. On the ROM_BITS/(BYTE_W/2)-th exchange it wraps to 0, and pass_done_o pulses together with rx_valid_o. It is cleared while accel_en_i is 0.
- R9: The mode is taken from accel_en_i in the cycle the byte is accepted. Changing accel_en_i during the exchange does not alter how that exchange runs.
- R10: While an exchange is in progress tx_ready_o is 0, and tx_valid_i is ignored. No extra exchange and no extra result follow.
- R11: slot_req_o stays high, and slot_wr_bit_o stays stable, until slot_done_i acknowledges the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| accel_en_i | input | 1 | Search assist enable |
| tx_valid_i | input | 1 | Byte offered by the host |
| tx_byte_i | input | BYTE_W | Byte to send, or the preference bits in search mode |
| tx_ready_o | output | 1 | Block idle, a byte can be accepted |
| rx_valid_o | output | 1 | One-cycle pulse: rx_byte_o is valid |
| rx_byte_o | output | BYTE_W | Received byte, or packed choices and flags |
| slot_req_o | output | 1 | Request one bus slot |
| slot_wr_bit_o | output | 1 | Bit to drive in the requested slot |
| slot_done_i | input | 1 | Slot finished, rd bit valid |
| slot_rd_bit_i | input | 1 | Level sampled in the slot |
| exch_idx_o | output | $clog2(ROM_BITS/(BYTE_W/2)) | Search exchanges completed in this pass |
| pass_done_o | output | 1 | Pulse on the exchange that completes a pass |

## Verification
The bench builds the block with its defaults, BYTE_W=8 and ROM_BITS=64. That gives four positions per byte and a sixteen-exchange pass, so a full identifier walk and the counter wrap with its pass pulse are both reachable in a short run. A slot responder with varying latency exercises request holding. Explicit sample pairs drive each of the three decision cases, with the preference bit both set and clear.

// File: rtl/owsra_pkg.sv
package owsra_pkg;

  typedef enum logic [1:0] {
    PH_PLAIN = 2'd0,
    PH_TRUE  = 2'd1,
    PH_CMP   = 2'd2,
    PH_DIR   = 2'd3
  } phase_e;

  typedef struct packed {
    logic dir;
    logic disc;
  } choice_t;

  // Branch decision from the two read samples and the host preference.
  function automatic choice_t pick_dir(input logic b_true, input logic b_cmp,
                                       input logic pref);
    choice_t r;
    if (b_true != b_cmp) begin
      r.dir  = b_true;
      r.disc = 1'b0;
    end else if (!b_true) begin
      r.dir  = pref;
      r.disc = 1'b1;
    end else begin
      r.dir  = 1'b1;
      r.disc = 1'b1;
    end
    return r;
  endfunction

  // Bit position of the chosen bit for search position p.
  function automatic int unsigned odd_pos(input int unsigned p);
    return 2 * p + 1;
  endfunction

  // Bit position of the conflict flag for search position p.
  function automatic int unsigned even_pos(input int unsigned p);
    return 2 * p;
  endfunction

endpackage

// File: rtl/owsra_seq.sv
module owsra_seq
  import owsra_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       accel_i,
  input  logic                       slot_done_i,
  output logic                       busy_o,
  output phase_e                     phase_o,
  output logic [$clog2(BYTE_W)-1:0]  idx_o,
  output logic                       step_o,
  output logic                       finish_o
);

  localparam int POS_N = BYTE_W / 2;
  localparam int IDX_W = $clog2(BYTE_W);

  logic              busy_q;
  phase_e            phase_q;
  logic [IDX_W-1:0]  idx_q;
  logic              last_slot;

  always_comb begin
    last_slot = 1'b0;
    if (phase_q == PH_PLAIN && idx_q == IDX_W'(BYTE_W - 1)) last_slot = 1'b1;
    if (phase_q == PH_DIR   && idx_q == IDX_W'(POS_N - 1))  last_slot = 1'b1;
  end

  assign step_o   = busy_q & slot_done_i;
  assign finish_o = step_o & last_slot;
  assign busy_o   = busy_q;
  assign phase_o  = phase_q;
  assign idx_o    = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= PH_PLAIN;
      idx_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        idx_q   <= '0;
        phase_q <= accel_i ? PH_TRUE : PH_PLAIN;
      end
    end else if (slot_done_i) begin
      unique case (phase_q)
        PH_PLAIN: begin
          if (last_slot) busy_q <= 1'b0;
          else           idx_q  <= idx_q + 1'b1;
        end
        PH_TRUE: phase_q <= PH_CMP;
        PH_CMP:  phase_q <= PH_DIR;
        PH_DIR: begin
          if (last_slot) begin
            busy_q <= 1'b0;
          end else begin
            idx_q   <= idx_q + 1'b1;
            phase_q <= PH_TRUE;
          end
        end
        default: phase_q <= PH_PLAIN;
      endcase
    end
  end

endmodule

// File: rtl/owsra_datapath.sv
module owsra_datapath
  import owsra_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_i,
  input  logic [BYTE_W-1:0]          tx_byte_i,
  input  phase_e                     phase_i,
  input  logic [$clog2(BYTE_W)-1:0]  idx_i,
  input  logic                       step_i,
  input  logic                       finish_i,
  input  logic                       slot_rd_bit_i,
  output logic                       slot_wr_bit_o,
  output logic [BYTE_W-1:0]          rx_byte_o,
  output logic                       rx_valid_o,
  output choice_t                    choice_o
);

  localparam int IDX_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] tx_q;
  logic [BYTE_W-1:0] rx_q;
  logic              smp_true_q;
  logic              smp_cmp_q;
  logic              rx_valid_q;
  logic [IDX_W-1:0]  odd_sel;
  logic [IDX_W-1:0]  even_sel;
  choice_t           choice;

  assign odd_sel  = IDX_W'(odd_pos(32'(idx_i)));
  assign even_sel = IDX_W'(even_pos(32'(idx_i)));
  assign choice   = pick_dir(smp_true_q, smp_cmp_q, tx_q[odd_sel]);
  assign choice_o = choice;

  always_comb begin
    unique case (phase_i)
      PH_PLAIN: slot_wr_bit_o = tx_q[idx_i];
      PH_DIR:   slot_wr_bit_o = choice.dir;
      default:  slot_wr_bit_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q       <= '0;
      rx_q       <= '0;
      smp_true_q <= 1'b0;
      smp_cmp_q  <= 1'b0;
      rx_valid_q <= 1'b0;
    end else begin
      rx_valid_q <= finish_i;
      if (load_i) begin
        tx_q <= tx_byte_i;
        rx_q <= '0;
      end
      if (step_i) begin
        unique case (phase_i)
          PH_PLAIN: rx_q[idx_i] <= slot_rd_bit_i;
          PH_TRUE:  smp_true_q  <= slot_rd_bit_i;
          PH_CMP:   smp_cmp_q   <= slot_rd_bit_i;
          PH_DIR: begin
            rx_q[odd_sel]  <= choice.dir;
            rx_q[even_sel] <= choice.disc;
          end
          default: ;
        endcase
      end
    end
  end

  assign rx_byte_o  = rx_q;
  assign rx_valid_o = rx_valid_q;

endmodule

// File: rtl/owsra_pass_cnt.sv
module owsra_pass_cnt #(
  parameter int EXCH_N = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear_i,
  input  logic                       bump_i,
  output logic [$clog2(EXCH_N)-1:0]  idx_o,
  output logic                       pass_done_o
);

  localparam int EXW = $clog2(EXCH_N);

  logic [EXW-1:0] cnt_q;
  logic           pass_q;
  logic           wrap;

  assign wrap = (cnt_q == EXW'(EXCH_N - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      cnt_q  <= '0;
      pass_q <= 1'b0;
    end else begin
      pass_q <= bump_i & wrap;
      if (bump_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  assign idx_o       = cnt_q;
  assign pass_done_o = pass_q;

endmodule

// File: rtl/owsra_top.sv
module owsra_top
  import owsra_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int ROM_BITS = 64
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         accel_en_i,
  input  logic                                         tx_valid_i,
  input  logic [BYTE_W-1:0]                            tx_byte_i,
  output logic                                         tx_ready_o,
  output logic                                         rx_valid_o,
  output logic [BYTE_W-1:0]                            rx_byte_o,
  output logic                                         slot_req_o,
  output logic                                         slot_wr_bit_o,
  input  logic                                         slot_done_i,
  input  logic                                         slot_rd_bit_i,
  output logic [$clog2(ROM_BITS/(BYTE_W/2))-1:0]       exch_idx_o,
  output logic                                         pass_done_o
);

  localparam int POS_N  = BYTE_W / 2;
  localparam int EXCH_N = ROM_BITS / POS_N;
  localparam int IDX_W  = $clog2(BYTE_W);

  logic             seq_busy;
  phase_e           seq_phase;
  logic [IDX_W-1:0] seq_idx;
  logic             seq_step;
  logic             seq_finish;
  logic             accept;
  logic             search_bump;
  choice_t          dp_choice;

  assign accept      = tx_valid_i & ~seq_busy;
  assign search_bump = seq_finish & (seq_phase == PH_DIR);
  assign tx_ready_o  = ~seq_busy;
  assign slot_req_o  = seq_busy;

  owsra_seq #(.BYTE_W(BYTE_W)) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (accept),
    .accel_i     (accel_en_i),
    .slot_done_i (slot_done_i),
    .busy_o      (seq_busy),
    .phase_o     (seq_phase),
    .idx_o       (seq_idx),
    .step_o      (seq_step),
    .finish_o    (seq_finish)
  );

  owsra_datapath #(.BYTE_W(BYTE_W)) dp_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_i        (accept),
    .tx_byte_i     (tx_byte_i),
    .phase_i       (seq_phase),
    .idx_i         (seq_idx),
    .step_i        (seq_step),
    .finish_i      (seq_finish),
    .slot_rd_bit_i (slot_rd_bit_i),
    .slot_wr_bit_o (slot_wr_bit_o),
    .rx_byte_o     (rx_byte_o),
    .rx_valid_o    (rx_valid_o),
    .choice_o      (dp_choice)
  );

  owsra_pass_cnt #(.EXCH_N(EXCH_N)) cnt_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (~accel_en_i),
    .bump_i      (search_bump),
    .idx_o       (exch_idx_o),
    .pass_done_o (pass_done_o)
  );

endmodule

// File: rtl/owsra_chk.sv
module owsra_chk #(
  parameter int EXW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           accel_en_i,
  input logic           tx_ready_o,
  input logic           rx_valid_o,
  input logic           slot_req_o,
  input logic           slot_wr_bit_o,
  input logic           slot_done_i,
  input logic           pass_done_o,
  input logic [EXW-1:0] exch_idx_o
);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req_o && !slot_done_i) |=> (slot_req_o && $stable(slot_wr_bit_o)));

  // R10
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |-> !slot_req_o);

  // R2
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  // R8
  pass_with_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done_o |-> rx_valid_o);

  // R8
  idx_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exch_idx_o != $past(exch_idx_o)) |-> (rx_valid_o || !$past(accel_en_i)));

  // R8
  idx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accel_en_i |=> (exch_idx_o == '0));

endmodule

bind owsra_top owsra_chk #(.EXW($clog2(ROM_BITS/(BYTE_W/2)))) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .accel_en_i    (accel_en_i),
  .tx_ready_o    (tx_ready_o),
  .rx_valid_o    (rx_valid_o),
  .slot_req_o    (slot_req_o),
  .slot_wr_bit_o (slot_wr_bit_o),
  .slot_done_i   (slot_done_i),
  .pass_done_o   (pass_done_o),
  .exch_idx_o    (exch_idx_o)
);

// File: tb/owsra_top_tb_top.sv
module owsra_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int BYTE_W     = 8;
  localparam int ROM_BITS   = 64;
  localparam int EXCH_N     = ROM_BITS / (BYTE_W / 2);
  localparam int EXW        = $clog2(EXCH_N);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              accel_en = 1'b0;
  logic              tx_valid = 1'b0;
  logic [BYTE_W-1:0] tx_byte = '0;
  logic              tx_ready;
  logic              rx_valid;
  logic [BYTE_W-1:0] rx_byte;
  logic              slot_req;
  logic              slot_wr_bit;
  logic              slot_done = 1'b0;
  logic              slot_rd_bit = 1'b0;
  logic [EXW-1:0]    exch_idx;
  logic              pass_done;

  int checks = 0;
  int failures = 0;
  int tb_exch = 0;
  int slot_cnt = 0;
  logic [BYTE_W-1:0] last_rx;
  bit finished = 0;

  bit          wr_q[$];
  bit          rsp_q[$];
  logic [8:0]  exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  owsra_top #(.BYTE_W(BYTE_W), .ROM_BITS(ROM_BITS)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .accel_en_i    (accel_en),
    .tx_valid_i    (tx_valid),
    .tx_byte_i     (tx_byte),
    .tx_ready_o    (tx_ready),
    .rx_valid_o    (rx_valid),
    .rx_byte_o     (rx_byte),
    .slot_req_o    (slot_req),
    .slot_wr_bit_o (slot_wr_bit),
    .slot_done_i   (slot_done),
    .slot_rd_bit_i (slot_rd_bit),
    .exch_idx_o    (exch_idx),
    .pass_done_o   (pass_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Slot responder: answers each request after a varying latency.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && slot_req) begin
        repeat (slot_cnt % 3) @(negedge clk);
        slot_cnt++;
        if (wr_q.size() == 0) begin
          check(0, "R10", "unexpected slot", 1, 0);
        end else begin
          bit ew;
          ew = wr_q.pop_front();
          check(slot_wr_bit == ew, "R3", "slot write bit (R2/R11)", slot_wr_bit, ew);
        end
        slot_rd_bit = (rsp_q.size() != 0) ? rsp_q.pop_front() : 1'b1;
        slot_done = 1'b1;
        @(negedge clk);
        slot_done = 1'b0;
      end
    end
  end

  // Monitor: compares each result against the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && pass_done && !rx_valid)
        check(0, "R8", "pass pulse without result", 1, 0);
      if (rst_n && rx_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R10", "unexpected result", rx_byte, 0);
        end else begin
          logic [8:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rx_byte == e[7:0], t, "rx byte", rx_byte, e[7:0]);
          check(pass_done == e[8], "R8", "pass pulse", pass_done, e[8]);
          last_rx = rx_byte;
        end
      end
    end
  end

  task automatic launch(input logic [BYTE_W-1:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1;
    tx_byte  = b;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_result();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // mode 0 normal, 1 poke tx_valid while busy, 2 raise accel mid-exchange
  task automatic plain_xfer(input logic [BYTE_W-1:0] tx,
                            input logic [BYTE_W-1:0] rd, input int mode,
                            input string tag);
    for (int k = 0; k < BYTE_W; k++) begin
      wr_q.push_back(tx[k]);
      rsp_q.push_back(rd[k]);
    end
    exp_q.push_back({1'b0, rd});
    tag_q.push_back(tag);
    launch(tx);
    if (mode == 1) begin
      repeat (3) @(negedge clk);
      check(tx_ready == 1'b0, "R10", "ready while busy", tx_ready, 0);
      tx_valid = 1'b1;
      tx_byte  = 8'hA5;
      @(negedge clk);
      tx_valid = 1'b0;
    end else if (mode == 2) begin
      accel_en = 1'b1;
    end
    wait_result();
    if (mode == 1) begin
      repeat (40) @(negedge clk);
      check(slot_req == 1'b0, "R10", "no extra exchange", slot_req, 0);
    end
  endtask

  task automatic sra_xfer(input logic [BYTE_W-1:0] tx,
                          input logic [3:0] bt, input logic [3:0] bc,
                          input string tag);
    logic [BYTE_W-1:0] exp_rx;
    bit pass;
    exp_rx = '0;
    for (int p = 0; p < 4; p++) begin
      bit d, f;
      if (bt[p] == 1'b1 && bc[p] == 1'b0)      begin d = 1; f = 0; end
      else if (bt[p] == 1'b0 && bc[p] == 1'b1) begin d = 0; f = 0; end
      else if (bt[p] == 1'b0)                  begin d = tx[2*p+1]; f = 1; end
      else                                     begin d = 1; f = 1; end
      exp_rx[2*p+1] = d;
      exp_rx[2*p]   = f;
      wr_q.push_back(1'b1); rsp_q.push_back(bt[p]);
      wr_q.push_back(1'b1); rsp_q.push_back(bc[p]);
      wr_q.push_back(d);    rsp_q.push_back(1'b1);
    end
    tb_exch++;
    pass = (tb_exch == EXCH_N);
    if (pass) tb_exch = 0;
    exp_q.push_back({pass, exp_rx});
    tag_q.push_back(tag);
    launch(tx);
    wait_result();
    check(exch_idx == EXW'(tb_exch), "R8", "exchange index", exch_idx, tb_exch);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "WATCHDOG", "run timed out", 0, 1);
    finish_run();
  end

  initial begin
    logic [63:0] rom;
    logic [63:0] got;
    rom = 64'h5A3C_91E7_0F26_B4D8;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(tx_ready == 1'b1, "R1", "tx_ready", tx_ready, 1);
    check(rx_valid == 1'b0, "R1", "rx_valid", rx_valid, 0);
    check(slot_req == 1'b0, "R1", "slot_req", slot_req, 0);
    check(pass_done == 1'b0, "R1", "pass_done", pass_done, 0);
    check(exch_idx == '0, "R1", "exch_idx", exch_idx, 0);

    // R2 plain exchanges
    plain_xfer(8'h3C, 8'h96, 0, "R2");
    plain_xfer(8'hFF, 8'h00, 0, "R2");
    plain_xfer(8'h01, 8'hFE, 0, "R2");
    // R10 byte offered while busy
    plain_xfer(8'h5A, 8'h33, 1, "R10");
    // R9 enable raised after acceptance: still plain, counter untouched
    plain_xfer(8'hC3, 8'h69, 2, "R9");
    check(exch_idx == '0, "R9", "plain leaves index", exch_idx, 0);

    // R4 differing samples
    sra_xfer(8'h00, 4'b0101, 4'b1010, "R4");
    // R5 both zero, preference set then clear
    sra_xfer(8'hAA, 4'b0000, 4'b0000, "R5");
    sra_xfer(8'h00, 4'b0000, 4'b0000, "R5");
    sra_xfer(8'h88, 4'b0000, 4'b0000, "R5");
    // R6 both one
    sra_xfer(8'h00, 4'b1111, 4'b1111, "R6");
    // R7 mixed positions
    sra_xfer(8'h20, 4'b1001, 4'b0011, "R7");

    // R8 clear on disable
    @(negedge clk);
    accel_en = 1'b0;
    tb_exch = 0;
    @(negedge clk);
    @(negedge clk);
    check(exch_idx == '0, "R8", "cleared index", exch_idx, 0);
    accel_en = 1'b1;

    // R7 full pass of one device: 16 exchanges rebuild the identifier
    got = '0;
    for (int i = 0; i < EXCH_N; i++) begin
      logic [3:0] nb;
      nb = rom[4*i +: 4];
      sra_xfer(8'h00, nb, ~nb, "R7");
      for (int p = 0; p < 4; p++) got[4*i+p] = last_rx[2*p+1];
    end
    check(got == rom, "R7", "assembled identifier", got, rom);
    check(exch_idx == '0, "R8", "index wrapped", exch_idx, 0);

    // R8 plain exchange in between does not advance the count
    sra_xfer(8'hFF, 4'b0000, 4'b1111, "R4");
    accel_en = 1'b0;
    tb_exch = 0;
    plain_xfer(8'h0F, 8'hF0, 0, "R2");
    check(exch_idx == '0, "R8", "plain after disable", exch_idx, 0);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule